// File: doc/BRIEF.md
# Core voltage step sequencer

This block turns a requested core supply level, given in millivolts, into a 5-bit regulator target code. It then issues one write of a packed control word in which the same code fills three regulator target fields. After the write it holds a busy flag while the supply settles. The requester strobes a millivolt value and waits for a one-cycle done pulse. The block reports the millivolt level that the chosen code actually selects.

The settling wait is asymmetric and is counted in pulses of a 1 µs tick input, so the wait does not depend on the clock frequency. Each upward code step costs 3 µs. A downward move costs nothing. The first request after reset always takes a fixed long wait, because at that point the three rails may not agree. Once that first request is done, a request that maps to the code already in place causes no write and no wait.

Top module: `vcore_step_seq`

## Requirements
- R1: A request below 725 mV selects code 0.
- R2: A request above 1450 mV selects code 31.
- R3: From 725 mV to 1450 mV inclusive, the code is (mV − 700) / 25 with the remainder dropped. `applied_mv_o` always equals code × 25 + 700 for the code held in the lowest field.
- R4: A write puts the code into the 5-bit fields at bit 0, bit 9 and bit 18 of `ctl_word_o` and leaves every other bit unchanged. `ctl_we_o` is high for exactly the one cycle in which the new word first appears.
- R5: After the first request, a request whose code equals the current code causes no write and no busy period. `done_o` pulses in the cycle after acceptance.
- R6: A request that raises the code by N steps holds `busy_o` for exactly 3 × N tick pulses.
- R7: A request that lowers the code writes the word and does not raise `busy_o`. `done_o` pulses in the same cycle that `ctl_we_o` is high.
- R8: The first request after reset writes the word and holds `busy_o` for exactly 84 tick pulses, whatever code was held before.
- R9: A request that arrives while `busy_o` is high is ignored: no write, and no change to the word or to `applied_mv_o`.
- R10: `busy_o` rises in the cycle after a request is accepted. It falls in the same cycle that `done_o` pulses. A tick in the acceptance cycle is not counted.
- R11: Only `us_tick_i` pulses count toward the settling wait. Changing the spacing of the ticks changes the wait in clock cycles but not the wait in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, accepted when not busy |
| req_mv_i | input | MV_W | Requested level in millivolts |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| ctl_word_o | output | WORD_W | Packed regulator control word (shadow) |
| ctl_we_o | output | 1 | Write strobe for the control word |
| busy_o | output | 1 | Settling wait in progress |
| done_o | output | 1 | One-cycle completion pulse |
| applied_mv_o | output | MV_W | Level selected by the current code, in mV |

## Verification
The bench builds the block with its default field layout, but gives the reset word an alternating bit pattern whose lowest field holds code 5. As a result, preservation of the non-field bits and the "whatever the old code" rule for the first request can both be seen at the ports. A one-millivolt ascending sweep from 600 mV to 1500 mV covers every code boundary, both clamps and every single-step upward wait. A descending sweep with a different tick spacing covers the zero-wait path and the tick-only timebase. Large jumps, an injected request during a busy period, and a second reset that moves downward on its first request cover the remaining corners.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vcs_code_map.sv
module vcs_code_map #(
  parameter int MV_W    = 12,
  parameter int CODE_W  = 5,
  parameter int BASE_MV = 700,
  parameter int STEP_MV = 25
) (
  input  logic [MV_W-1:0]   mv_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int LOW_MV   = BASE_MV + STEP_MV;
  localparam int HIGH_MV  = BASE_MV + STEP_MV * (CODE_MAX - 1);

  logic [MV_W-1:0] diff;
  logic [MV_W-1:0] quot;

  always_comb begin
    diff   = mv_i - MV_W'(BASE_MV);
    quot   = diff / MV_W'(STEP_MV);
    code_o = quot[CODE_W-1:0];
    if (mv_i < MV_W'(LOW_MV)) begin
      code_o = '0;
    end else if (mv_i > MV_W'(HIGH_MV)) begin
      code_o = CODE_W'(CODE_MAX);
    end
  end
endmodule

// File: rtl/vcs_shadow_word.sv
module vcs_shadow_word #(
  parameter int                 WORD_W       = 32,
  parameter int                 CODE_W       = 5,
  parameter int                 NUM_FIELDS   = 3,
  parameter int                 FIELD_STRIDE = 9,
  parameter logic [WORD_W-1:0]  RESET_WORD   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CODE_W-1:0] cur_code_o
);
  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] field_mask;
  logic [WORD_W-1:0] field_bits;

  // One mask and value slice per rail field, built by generate.
  logic [NUM_FIELDS-1:0][WORD_W-1:0] mask_part;
  logic [NUM_FIELDS-1:0][WORD_W-1:0] bits_part;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int LSB = g * FIELD_STRIDE;
    assign mask_part[g] = {{(WORD_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << LSB;
    assign bits_part[g] = {{(WORD_W-CODE_W){1'b0}}, code_i} << LSB;
  end

  always_comb begin
    field_mask = '0;
    field_bits = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      field_mask = field_mask | mask_part[i];
      field_bits = field_bits | bits_part[i];
    end
    merged = (shadow_q & ~field_mask) | field_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RESET_WORD;
    end else if (load_i) begin
      shadow_q <= merged;
    end
  end

  assign word_o     = shadow_q;
  assign cur_code_o = shadow_q[CODE_W-1:0];
endmodule

// File: rtl/vcs_settle_timer.sv
module vcs_settle_timer #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [DLY_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= load_val_i;
    end else if (tick_i && (remain_q != '0)) begin
      remain_q <= remain_q - DLY_W'(1);
    end
  end

  assign expire_o = tick_i && (remain_q == DLY_W'(1));
endmodule

// File: rtl/vcore_step_seq.sv
module vcore_step_seq #(
  parameter int                MV_W         = 12,
  parameter int                CODE_W       = 5,
  parameter int                WORD_W       = 32,
  parameter int                NUM_FIELDS   = 3,
  parameter int                FIELD_STRIDE = 9,
  parameter int                BASE_MV      = 700,
  parameter int                STEP_MV      = 25,
  parameter int                US_PER_STEP  = 3,
  parameter int                INIT_STEPS   = 28,
  parameter logic [WORD_W-1:0] RESET_WORD   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [MV_W-1:0]   req_mv_i,
  input  logic              us_tick_i,
  output logic [WORD_W-1:0] ctl_word_o,
  output logic              ctl_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [MV_W-1:0]   applied_mv_o
);
  import vcs_pkg::*;

  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int INIT_DLY = INIT_STEPS * US_PER_STEP;
  localparam int MAX_DLY  = max_int(CODE_MAX * US_PER_STEP, INIT_DLY);
  localparam int DLY_W    = $clog2(MAX_DLY + 1);
  localparam int RESET_MV = BASE_MV + int'(RESET_WORD[CODE_W-1:0]) * STEP_MV;

  seq_state_e        state_q;
  logic              primed_q;
  logic              we_q;
  logic              done_q;
  logic [MV_W-1:0]   applied_q;

  logic [CODE_W-1:0] new_code;
  logic [CODE_W-1:0] cur_code;
  logic              accept;
  logic              do_write;
  logic [DLY_W-1:0]  wait_len;
  logic [MV_W-1:0]   new_mv;
  logic              expire;

  vcs_code_map #(
    .MV_W(MV_W), .CODE_W(CODE_W), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
  ) u_map (
    .mv_i(req_mv_i), .code_o(new_code)
  );

  assign accept   = req_i && (state_q == ST_IDLE);
  assign do_write = !primed_q || (new_code != cur_code);
  assign new_mv   = MV_W'(BASE_MV) + MV_W'(new_code) * MV_W'(STEP_MV);

  always_comb begin
    wait_len = '0;
    if (!primed_q) begin
      wait_len = DLY_W'(INIT_DLY);
    end else if (new_code > cur_code) begin
      wait_len = DLY_W'(new_code - cur_code) * DLY_W'(US_PER_STEP);
    end
  end

  vcs_shadow_word #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .NUM_FIELDS(NUM_FIELDS),
    .FIELD_STRIDE(FIELD_STRIDE), .RESET_WORD(RESET_WORD)
  ) u_shadow (
    .clk(clk), .rst(rst), .load_i(accept && do_write), .code_i(new_code),
    .word_o(ctl_word_o), .cur_code_o(cur_code)
  );

  vcs_settle_timer #(
    .DLY_W(DLY_W)
  ) u_timer (
    .clk(clk), .rst(rst), .load_i(accept), .load_val_i(wait_len),
    .tick_i(us_tick_i), .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      primed_q  <= 1'b0;
      we_q      <= 1'b0;
      done_q    <= 1'b0;
      applied_q <= MV_W'(RESET_MV);
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      if (accept) begin
        primed_q <= 1'b1;
        if (do_write) begin
          we_q      <= 1'b1;
          applied_q <= new_mv;
        end
        if (wait_len != '0) begin
          state_q <= ST_SETTLE;
        end else begin
          done_q <= 1'b1;
        end
      end else if ((state_q == ST_SETTLE) && expire) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  assign ctl_we_o     = we_q;
  assign busy_o       = (state_q == ST_SETTLE);
  assign done_o       = done_q;
  assign applied_mv_o = applied_q;
endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
  parameter int MV_W         = 12,
  parameter int CODE_W       = 5,
  parameter int WORD_W       = 32,
  parameter int NUM_FIELDS   = 3,
  parameter int FIELD_STRIDE = 9,
  parameter int BASE_MV      = 700,
  parameter int STEP_MV      = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic [WORD_W-1:0] ctl_word_o,
  input logic              ctl_we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [MV_W-1:0]   applied_mv_o
);
  // R4: every rail field carries the lowest field's code after a write
  for (genvar g = 1; g < NUM_FIELDS; g++) begin : g_rail
    p_fields_match_r4: assert property (@(posedge clk) disable iff (rst)
      ctl_we_o |-> (ctl_word_o[g*FIELD_STRIDE +: CODE_W] == ctl_word_o[CODE_W-1:0]));
  end

  p_applied_consistent_r3: assert property (@(posedge clk) disable iff (rst)
    applied_mv_o == (MV_W'(BASE_MV) + MV_W'(ctl_word_o[CODE_W-1:0]) * MV_W'(STEP_MV)));

  p_ignore_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ($stable(ctl_word_o) && !ctl_we_o && $stable(applied_mv_o)));

  p_done_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  p_busy_from_write_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ctl_we_o);

  p_write_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
    ctl_we_o |-> $past(req_i));

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && busy_o));
endmodule

bind vcore_step_seq vcs_checker #(
  .MV_W(MV_W), .CODE_W(CODE_W), .WORD_W(WORD_W), .NUM_FIELDS(NUM_FIELDS),
  .FIELD_STRIDE(FIELD_STRIDE), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
) u_vcs_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .ctl_word_o(ctl_word_o),
  .ctl_we_o(ctl_we_o), .busy_o(busy_o), .done_o(done_o),
  .applied_mv_o(applied_mv_o)
);

// File: tb/tb_vcore_step_seq.sv
module tb_vcore_step_seq;
  localparam logic [31:0] RST_WORD = 32'hA5A5_A5A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [11:0] req_mv = '0;
  logic        us_tick = 1'b0;
  logic [31:0] ctl_word;
  logic        ctl_we, busy, done;
  logic [11:0] applied_mv;

  int checks = 0;
  int errors = 0;
  int tick_gap = 4;
  int tick_cnt = 0;
  int cycles = 0;
  bit finished = 0;

  int          m_code;
  bit          m_first;
  logic [31:0] m_word;

  vcore_step_seq #(.RESET_WORD(RST_WORD)) dut (
    .clk(clk), .rst(rst), .req_i(req), .req_mv_i(req_mv), .us_tick_i(us_tick),
    .ctl_word_o(ctl_word), .ctl_we_o(ctl_we), .busy_o(busy), .done_o(done),
    .applied_mv_o(applied_mv)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (tick_cnt >= tick_gap - 1) begin
      tick_cnt <= 0;
      us_tick  <= 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1;
      us_tick  <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_code(input int mv);
    if (mv < 725) return 0;
    if (mv > 1450) return 31;
    return (mv - 700) / 25;
  endfunction

  function automatic logic [31:0] put_code(input logic [31:0] w, input int c);
    logic [31:0] r = w;
    for (int i = 0; i < 3; i++) r[i*9 +: 5] = c[4:0];
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_code  = int'(RST_WORD[4:0]);
    m_first = 1;
    m_word  = RST_WORD;
  endtask

  task automatic do_req(input int mv, input int inj = -1);
    int c = exp_code(mv);
    bit wr = m_first || (c != m_code);
    int d;
    int ticks = 0;
    int n = 0;
    int old_mv = 700 + m_code * 25;
    if (m_first) d = 84;
    else if (c > m_code) d = 3 * (c - m_code);
    else d = 0;
    @(negedge clk);
    check(!busy, "R9 idle before request", busy, 0);
    req = 1'b1;
    req_mv = 12'(mv);
    @(negedge clk);
    req = 1'b0;
    if (wr) begin
      m_word = put_code(m_word, c);
      m_code = c;
    end
    check(ctl_we == wr, wr ? "R4 write strobe" : "R5 no write on same code", ctl_we, wr);
    check(ctl_word == m_word, (mv < 725) ? "R1 low clamp word" :
          (mv > 1450) ? "R2 high clamp word" : "R3 R4 code word", ctl_word, m_word);
    check(applied_mv == 12'(700 + m_code * 25), "R3 applied mV", applied_mv,
          wr ? 700 + c * 25 : old_mv);
    if (d == 0) begin
      check(!busy && done, wr ? "R7 down move no wait" : "R5 same code done",
            {busy, done}, 2'b01);
    end else begin
      check(busy && !done, "R10 busy after accept", {busy, done}, 2'b10);
      while (busy && ticks < 200) begin
        if (n > 0) check(!ctl_we, "R9 no write during busy", ctl_we, 0);
        if (us_tick) ticks++;
        if (inj >= 0 && n == 5) begin
          req = 1'b1;
          req_mv = 12'(inj);
        end else begin
          req = 1'b0;
        end
        n++;
        @(negedge clk);
      end
      req = 1'b0;
      check(done, "R10 done on busy fall", done, 1);
      check(ticks == d, m_first ? "R8 first request wait" : "R6 R11 upward wait",
            ticks, d);
      if (inj >= 0) begin
        check(ctl_word == m_word, "R9 ignored request word", ctl_word, m_word);
        check(applied_mv == 12'(700 + m_code * 25), "R9 ignored request mV",
              applied_mv, 700 + m_code * 25);
      end
    end
    m_first = 0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check(ctl_word == RST_WORD, "R4 reset word", ctl_word, RST_WORD);
    check(!busy && !done && !ctl_we, "R10 reset idle", {busy, done, ctl_we}, 0);
    check(applied_mv == 12'd825, "R3 reset applied mV", applied_mv, 825);

    do_req(900);             // R8: first request, code 5 -> 8
    do_req(1450, 600);       // R6 + R9: 8 -> 30 with injected request
    do_req(1450);            // R5: same code
    do_req(1460);            // R2: clamp to 31
    do_req(4000);            // R2 + R5
    do_req(700);             // R1 + R7
    do_req(0);               // R1 + R5
    do_req(724);             // R1
    do_req(725);             // R3 lower edge, one step up

    for (int mv = 600; mv <= 1500; mv++) do_req(mv);
    tick_gap = 7;            // R11: different tick spacing
    for (int mv = 1500; mv >= 600; mv -= 5) do_req(mv);
    do_req(725);
    do_req(1450);
    do_req(1000);
    do_req(1449);

    do_reset();
    do_req(650);             // R8: first request moving down still waits
    do_req(650);             // R5
    tick_gap = 2;
    do_req(1200);            // R6 R11

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule